// File: doc/BRIEF.md
# Timer Master Trigger Output Generator

An up-counting timer with a parameterised number of output-compare channels (two by default) that produces one trigger line for keeping slave timers in step. A three-bit select field in the control word picks which internal event drives that line. The candidates are a software reinitialise pulse, the counter-enable level, the wrap (update) event, a compare-1 match pulse, and the reference level of channel 1 or channel 2.

Software configures the block through a simple write port: a control word, the wrap (reload) value, one compare value per channel, a reinitialise strobe and a clear for the channel 1 flag. A slave trigger input can gate the counter. In enable mode, the trigger line shows the software run bit ORed with that gated input, and the gated part lags by one register stage.

Top module: `tmr_master_trig`

## Requirements
- R1: After reset the counter is zero, all registers are zero, the select field is 000, and `trg_o`, `oc_ref_o` and `cc1_flag_o` are all low.
- R2: While enabled, the counter advances by one each cycle. In a cycle where it equals the reload value, it returns to zero on the next edge and an update event is raised for that one cycle.
- R3: Writing 1 to bit 0 at address 2 forces the counter to zero on the next edge, whether or not the counter is enabled. In the cycle of that write, an update event and a reinitialise pulse are raised. Select 000 drives `trg_o` with that pulse.
- R4: Select 001 drives `trg_o` with the run bit ORed with a one-cycle-delayed copy of (gate-enable bit AND `slv_trig_i`). The undelayed OR is the counter enable.
- R5: Select 010 drives `trg_o` with the update event: a wrap or a reinitialise.
- R6: Select 011 drives `trg_o` high for exactly the cycles in which the counter is enabled and equals compare 1. This holds even while `cc1_flag_o` is already set.
- R7: Select 100 drives `trg_o` with `oc_ref_o[0]`. Select 101 drives it with `oc_ref_o[1]`.
- R8: Select codes 110 and 111 hold `trg_o` low.
- R9: `oc_ref_o[i]` is high exactly while the counter value is below the compare value of channel i (address 4+i).
- R10: `cc1_flag_o` rises on the edge after a compare-1 match. It stays high until a write at address 3 with bit 0 equal to 0. A match in the same cycle as that write wins over the clear.
- R11: The control word at address 0 uses bit 0 as run, bit 1 as gate-enable and bits 6:4 as the select field. Its other bits have no effect. The reload value is at address 1.
- R12: While not enabled and not reinitialised, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| slv_trig_i | input | 1 | Slave trigger input for gated counting |
| trg_o | output | 1 | Master trigger output |
| oc_ref_o | output | CH_N | Compare reference levels, one per channel |
| cc1_flag_o | output | 1 | Channel 1 capture/compare flag |

## Verification
The bench builds the block with an 8-bit counter and the default two channels. A reload value of 5 then gives a wrap period of six cycles, so several update events, repeated compare-1 matches with the flag already set, and the switch points of both reference outputs all occur in short runs of every select code. With the narrow data word, ignored control bits and the behaviour of the whole counter range stay within a few dozen cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [2:0] {
      TRG_REINIT  = 3'd0,
      TRG_ENABLE  = 3'd1,
      TRG_UPDATE  = 3'd2,
      TRG_CMPPULS = 3'd3,
      TRG_REF1    = 3'd4,
      TRG_REF2    = 3'd5,
      TRG_RSV6    = 3'd6,
      TRG_RSV7    = 3'd7
   } trg_sel_e;

   localparam int unsigned ADR_CTRL     = 0;
   localparam int unsigned ADR_RELOAD   = 1;
   localparam int unsigned ADR_EVENT    = 2;
   localparam int unsigned ADR_FLAGCLR  = 3;
   localparam int unsigned ADR_CMP_BASE = 4;

   localparam int unsigned CTL_RUN_BIT  = 0;
   localparam int unsigned CTL_GATE_BIT = 1;
   localparam int unsigned CTL_SEL_LSB  = 4;
   localparam int unsigned CTL_SEL_W    = 3;

endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign wrap_o = en_i && (cnt_q == reload_i);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (wrap_o)  cnt_q <= '0;
      else if (en_i)    cnt_q <= cnt_q + CNT_ONE;
   end

   p_wrap_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cnt_q == reload_i) |=> (cnt_q == '0));

   p_reinit_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));

   p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned CH_N  = 2
) (
   input  logic [CNT_W-1:0]           cnt_i,
   input  logic [CH_N-1:0][CNT_W-1:0] cmp_i,
   output logic [CH_N-1:0]            ref_o
);

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      assign ref_o[c] = (cnt_i < cmp_i[c]);
   end

endmodule

// File: rtl/tmr_trg_mux.sv
module tmr_trg_mux
   import tmr_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  trg_sel_e sel_i,
   input  logic     reinit_i,
   input  logic     run_i,
   input  logic     gated_i,
   input  logic     upd_i,
   input  logic     match_i,
   input  logic     ref1_i,
   input  logic     ref2_i,
   output logic     trg_o
);

   logic gated_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gated_q <= 1'b0;
      else         gated_q <= gated_i;
   end

   always_comb begin
      unique case (sel_i)
         TRG_REINIT:  trg_o = reinit_i;
         TRG_ENABLE:  trg_o = run_i | gated_q;
         TRG_UPDATE:  trg_o = upd_i;
         TRG_CMPPULS: trg_o = match_i;
         TRG_REF1:    trg_o = ref1_i;
         TRG_REF2:    trg_o = ref2_i;
         default:     trg_o = 1'b0;
      endcase
   end

   p_enable_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == TRG_ENABLE && run_i) |-> trg_o);

   p_gate_late_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gated_i && sel_i == TRG_ENABLE) |=> (trg_o || sel_i != TRG_ENABLE));

endmodule

// File: rtl/tmr_master_trig.sv
module tmr_master_trig
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CH_N   = 2,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic              slv_trig_i,
   output logic              trg_o,
   output logic [CH_N-1:0]   oc_ref_o,
   output logic              cc1_flag_o
);

   localparam int unsigned DATA_W = CNT_W;
   localparam int unsigned ADR_SPAN = 1 << ADDR_W;

   if (DATA_W < CTL_SEL_LSB + CTL_SEL_W) begin : g_bad_width
      $fatal(1, "CNT_W too small for the control word");
   end
   if (CH_N < 2) begin : g_bad_ch
      $fatal(1, "CH_N must be at least 2");
   end
   if (ADR_CMP_BASE + CH_N > ADR_SPAN) begin : g_bad_addr
      $fatal(1, "ADDR_W too small for CH_N compare registers");
   end

   logic                          run_q, gate_q;
   trg_sel_e                      sel_q;
   logic [CNT_W-1:0]              reload_q;
   logic [CH_N-1:0][CNT_W-1:0]    cmp_q;
   logic                          flag_q;

   logic             wr_ctrl, wr_reload, wr_clr, reinit;
   logic             gated, cnt_en, wrap, upd, match;
   logic [CNT_W-1:0] cnt;
   logic             unused_wdata;

   assign unused_wdata = ^wr_data_i;

   assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL));
   assign wr_reload = wr_en_i && (wr_addr_i == ADDR_W'(ADR_RELOAD));
   assign reinit    = wr_en_i && (wr_addr_i == ADDR_W'(ADR_EVENT)) && wr_data_i[0];
   assign wr_clr    = wr_en_i && (wr_addr_i == ADDR_W'(ADR_FLAGCLR)) && !wr_data_i[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         gate_q <= 1'b0;
         sel_q  <= TRG_REINIT;
      end else if (wr_ctrl) begin
         run_q  <= wr_data_i[CTL_RUN_BIT];
         gate_q <= wr_data_i[CTL_GATE_BIT];
         sel_q  <= trg_sel_e'(wr_data_i[CTL_SEL_LSB +: CTL_SEL_W]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        reload_q <= '0;
      else if (wr_reload) reload_q <= wr_data_i;
   end

   for (genvar c = 0; c < CH_N; c++) begin : g_cmp_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            cmp_q[c] <= '0;
         else if (wr_en_i && wr_addr_i == ADDR_W'(ADR_CMP_BASE + c))
            cmp_q[c] <= wr_data_i;
      end
   end

   assign gated  = gate_q & slv_trig_i;
   assign cnt_en = run_q | gated;

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (cnt_en),
      .clr_i    (reinit),
      .reload_i (reload_q),
      .cnt_o    (cnt),
      .wrap_o   (wrap)
   );

   tmr_cmp_bank #(.CNT_W(CNT_W), .CH_N(CH_N)) u_cmp (
      .cnt_i (cnt),
      .cmp_i (cmp_q),
      .ref_o (oc_ref_o)
   );

   assign upd   = wrap | reinit;
   assign match = cnt_en && (cnt == cmp_q[0]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q <= 1'b0;
      else if (match)  flag_q <= 1'b1;
      else if (wr_clr) flag_q <= 1'b0;
   end
   assign cc1_flag_o = flag_q;

   tmr_trg_mux u_mux (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel_q),
      .reinit_i (reinit),
      .run_i    (run_q),
      .gated_i  (gated),
      .upd_i    (upd),
      .match_i  (match),
      .ref1_i   (oc_ref_o[0]),
      .ref2_i   (oc_ref_o[1]),
      .trg_o    (trg_o)
   );

   p_flag_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match |=> cc1_flag_o);

   p_flag_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cc1_flag_o && !wr_clr) |=> cc1_flag_o);

   p_pulse_every_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == TRG_CMPPULS && cc1_flag_o && match) |-> trg_o);

   p_rsvd_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == TRG_RSV6 || sel_q == TRG_RSV7) |-> !trg_o);

   p_reinit_trg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q == TRG_REINIT && reinit) |-> trg_o);

endmodule

// File: tb/tmr_master_trig_tb.sv
module tmr_master_trig_tb;

   localparam int unsigned CW = 8;
   localparam int unsigned CH = 2;
   localparam int unsigned AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          slv = 1'b0;
   logic          trg;
   logic [CH-1:0] oc_ref;
   logic          flag;

   always #2 clk = ~clk;

   tmr_master_trig #(.CNT_W(CW), .CH_N(CH), .ADDR_W(AW)) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .slv_trig_i (slv),
      .trg_o      (trg),
      .oc_ref_o   (oc_ref),
      .cc1_flag_o (flag)
   );

   typedef struct {
      logic          trg;
      logic [CH-1:0] ref_lv;
      logic          flag;
      string         tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // requirement-level expectation state
   logic [CW-1:0] m_cnt = '0, m_reload = '0, m_c1 = '0, m_c2 = '0;
   logic m_run = 0, m_gate = 0, m_flag = 0, m_gq = 0;
   logic [2:0] m_sel = '0;

   task automatic cyc(input logic w, input logic [AW-1:0] a,
                      input logic [CW-1:0] d, input logic s, input string tag);
      logic en, ug, mt, up, r1, r2, t;
      exp_t e;
      @(negedge clk);
      wr_en = w; wr_addr = a; wr_data = d; slv = s;
      en = m_run | (m_gate & s);
      ug = w && a == 2 && d[0];
      mt = en && m_cnt == m_c1;
      up = ug | (en && m_cnt == m_reload);
      r1 = m_cnt < m_c1;
      r2 = m_cnt < m_c2;
      case (m_sel)
         3'd0: t = ug;
         3'd1: t = m_run | m_gq;
         3'd2: t = up;
         3'd3: t = mt;
         3'd4: t = r1;
         3'd5: t = r2;
         default: t = 1'b0;
      endcase
      e.trg = t; e.ref_lv = {r2, r1}; e.flag = m_flag; e.tag = tag;
      q.push_back(e);
      m_gq = m_gate & s;
      if (mt) m_flag = 1;
      else if (w && a == 3 && !d[0]) m_flag = 0;
      if (ug) m_cnt = '0;
      else if (en) m_cnt = (m_cnt == m_reload) ? '0 : m_cnt + 1'b1;
      if (w) begin
         case (a)
            3'd0: begin m_run = d[0]; m_gate = d[1]; m_sel = d[6:4]; end
            3'd1: m_reload = d;
            3'd4: m_c1 = d;
            3'd5: m_c2 = d;
            default: ;
         endcase
      end
   endtask

   task automatic idle(input int n, input logic s, input string tag);
      for (int i = 0; i < n; i++) cyc(0, '0, '0, s, tag);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d, input string tag);
      cyc(1, a, d, 0, tag);
   endtask

   // monitor: pop and compare away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (trg !== e.trg || oc_ref !== e.ref_lv || flag !== e.flag) begin
               n_bad++;
               $display("FAIL %s: trg/ref/flag got %b/%b/%b expected %b/%b/%b",
                        e.tag, trg, oc_ref, flag, e.trg, e.ref_lv, e.flag);
            end
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: got hung expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2, 0, "R1 reset state");
      // R3 reinitialise pulse with select 000, counter stopped
      wr(3'd2, 8'h01, "R3 reinit pulse");
      idle(1, 0, "R3 after reinit");
      // R11 control with ignored bits: 0x25 -> run=1, select=010
      wr(3'd1, 8'd5, "R11 reload write");
      wr(3'd4, 8'd2, "R9 cmp1 write");
      wr(3'd5, 8'd4, "R9 cmp2 write");
      wr(3'd0, 8'h25, "R11 control fields");
      idle(14, 0, "R2 R5 R9 update on wrap");
      wr(3'd2, 8'h01, "R5 reinit counts as update");
      idle(3, 0, "R2 after reinit");
      // R6 compare pulse mode, flag already set
      wr(3'd0, 8'h31, "R6 select 011");
      idle(14, 0, "R6 R10 pulse while flag set");
      wr(3'd3, 8'h01, "R10 write 1 ignored");
      wr(3'd3, 8'h00, "R10 clear flag");
      idle(4, 0, "R10 flag after clear");
      // R7 reference levels
      wr(3'd0, 8'h41, "R7 select 100");
      idle(8, 0, "R7 ref1 on trg");
      wr(3'd0, 8'h51, "R7 select 101");
      idle(8, 0, "R7 ref2 on trg");
      // R8 reserved selects
      wr(3'd0, 8'h61, "R8 select 110");
      idle(7, 0, "R8 reserved low");
      wr(3'd0, 8'h71, "R8 select 111");
      idle(7, 0, "R8 reserved low");
      // R4 enable mode with gated slave input
      wr(3'd0, 8'h12, "R4 gated enable select 001");
      idle(3, 0, "R4 gate closed");
      idle(5, 1, "R4 gate open delayed");
      idle(4, 0, "R4 gate closed again");
      wr(3'd0, 8'h11, "R4 run bit");
      idle(3, 1, "R4 run ignores gate enable off");
      // R12 hold when stopped
      wr(3'd0, 8'h20, "R12 stop");
      idle(6, 1, "R12 counter holds");
      wr(3'd2, 8'h01, "R3 reinit while stopped");
      idle(4, 0, "R3 R12 zero held");
      // R2 larger reload, covers full wrap
      wr(3'd1, 8'd9, "R2 reload 9");
      wr(3'd0, 8'h21, "R2 run select 010");
      idle(22, 0, "R2 wrap at reload 9");
      wait (q.size() == 0);
      @(negedge clk);
      #2;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule